// File: doc/BRIEF.md
# Port Pin Change Detector with Weak Pull-Up Control

This block watches a selected group of pins on an 8-bit general-purpose port (by default the four most significant pins) and raises a sticky change flag when any of them differs from a stored reference. The pin must be configured as an input to take part. The reference is not the previous cycle's pin level. It is a snapshot of the port taken at the most recent port access, either a read or a write. Software services the flag by accessing the port, which takes a new snapshot and ends the mismatch, and then clearing the flag. While a mismatch remains, the flag is set again on every cycle, so a clear on its own cannot remove it.

The flag also drives a wake request so a sleeping device can resume on a key press or a line change. The same block produces the per-pin weak pull-up enables for the whole port. A single active-low global control turns them on. A pin configured as an output never gets a pull-up.

Top module: `pin_change_monitor`

## Requirements
- R1: Only pins whose bit is set in parameter WATCH_MASK (default 0xF0, pins 7..4) take part in change detection; level changes on pins 3..0 never set the flag.
- R2: A watched pin whose direction bit is 0 (output) is excluded from the comparison and cannot set the flag.
- R3: When any watched input pin (direction bit 1) differs from its reference bit on a clock edge, `changeFlag` reads 1 after that edge.
- R4: While a mismatch persists, asserting `flagClear` leaves `changeFlag` at 1.
- R5: A cycle with `portAccess` high captures all pin levels as the new reference; a `flagClear` on a later edge with no mismatch makes `changeFlag` 0 after that edge.
- R6: When `flagClear` and a mismatch occur on the same edge, the flag is set. This includes an edge on which `portAccess` is also high, because the comparison uses the reference held before that edge.
- R7: `wakeReq` equals `changeFlag` in every cycle.
- R8: After each edge out of reset, `pullUpOn[i]` is 1 exactly when `pullUpEnN` was 0 and `dirIsInput[i]` was 1 at that edge.
- R9: On an edge with `rstN` low, the flag and all pull-up enables become 0 and the reference is loaded from the pin levels, so steady pins raise no flag after reset.
- R10: Turning a watched pin from output to input raises no flag when its level equals the stored reference bit.
- R11: Once set, the flag stays at 1 after the mismatch ends, until a `flagClear` on an edge without a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| pinLevel | input | 8 | Sampled pin levels of the port |
| dirIsInput | input | 8 | Per-pin direction, 1 = input, 0 = output |
| portAccess | input | 1 | Port read or write strobe, captures the reference |
| flagClear | input | 1 | Request to clear the change flag |
| pullUpEnN | input | 1 | Global weak pull-up enable, active low |
| changeFlag | output | 1 | Sticky change flag |
| wakeReq | output | 1 | Wake request from the change flag |
| pullUpOn | output | 8 | Per-pin weak pull-up enable |

## Verification
Some orderings are hard to reach from the ports. The main ones are a clear that lands on the same edge as a port access while the old reference still mismatches, and a direction flip from output to input at a moment when the pin does or does not equal a stale reference. Directed sequences build each of these on purpose. A long random phase then uses strongly biased strobes and pins that change rarely, so that mismatches last for many cycles and clears often fall inside them. A bench model checks every cycle.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic captureRef; // take a new reference snapshot
    logic pullArm;    // global pull-up permission
  } pcm_strobe_t;
endpackage

// File: rtl/pcm_datapath.sv
module pcm_datapath
  import pcm_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] WATCH_MASK = 8'hF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PORT_W-1:0] pinLevel,
  input  logic [PORT_W-1:0] dirIsInput,
  input  pcm_strobe_t       strobes,
  output logic              mismatch,
  output logic [PORT_W-1:0] pullUpOn
);
  logic [PORT_W-1:0] refSnap;
  logic [PORT_W-1:0] diffBits;

  // reference snapshot: loaded at reset and on each port access
  always_ff @(posedge clk) begin
    if (!rstN)                   refSnap <= pinLevel;
    else if (strobes.captureRef) refSnap <= pinLevel;
  end

  // per-pin compare, masked by watch set and direction
  assign diffBits = WATCH_MASK & dirIsInput & (pinLevel ^ refSnap);
  assign mismatch = |diffBits;

  // per-pin pull-up enables, forced off for outputs
  for (genvar p = 0; p < PORT_W; p++) begin : gPull
    always_ff @(posedge clk) begin
      if (!rstN) pullUpOn[p] <= 1'b0;
      else       pullUpOn[p] <= strobes.pullArm & dirIsInput[p];
    end
  end

  AST_PULL_OUTPUT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pullUpOn & ~$past(dirIsInput)) == '0)); // R8
  AST_OUTPUTS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((dirIsInput & WATCH_MASK) == '0) |-> !mismatch); // R2
endmodule

// File: rtl/pcm_control.sv
module pcm_control
  import pcm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        portAccess,
  input  logic        flagClear,
  input  logic        pullUpEnN,
  input  logic        mismatch,
  output pcm_strobe_t strobes,
  output logic        changeFlag,
  output logic        wakeReq
);
  logic flagQ;

  assign strobes.captureRef = portAccess;
  assign strobes.pullArm    = ~pullUpEnN;

  // set has priority over clear
  always_ff @(posedge clk) begin
    if (!rstN)          flagQ <= 1'b0;
    else if (mismatch)  flagQ <= 1'b1;
    else if (flagClear) flagQ <= 1'b0;
  end

  assign changeFlag = flagQ;
  assign wakeReq    = flagQ;

  AST_MISMATCH_SETS: assert property (@(posedge clk) disable iff (!rstN)
    mismatch |=> changeFlag); // R3
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (mismatch && flagClear) |=> changeFlag); // R6
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rstN)
    (flagClear && !mismatch) |=> !changeFlag); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (changeFlag && !flagClear) |=> changeFlag); // R11
endmodule

// File: rtl/pin_change_monitor.sv
module pin_change_monitor
  import pcm_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] WATCH_MASK = 8'hF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PORT_W-1:0] pinLevel,
  input  logic [PORT_W-1:0] dirIsInput,
  input  logic              portAccess,
  input  logic              flagClear,
  input  logic              pullUpEnN,
  output logic              changeFlag,
  output logic              wakeReq,
  output logic [PORT_W-1:0] pullUpOn
);
  pcm_strobe_t strobes;
  logic        mismatch;

  pcm_control ctrl_i (
    .clk(clk), .rstN(rstN), .portAccess(portAccess), .flagClear(flagClear),
    .pullUpEnN(pullUpEnN), .mismatch(mismatch), .strobes(strobes),
    .changeFlag(changeFlag), .wakeReq(wakeReq)
  );

  pcm_datapath #(.PORT_W(PORT_W), .WATCH_MASK(WATCH_MASK)) dp_i (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .dirIsInput(dirIsInput),
    .strobes(strobes), .mismatch(mismatch), .pullUpOn(pullUpOn)
  );

  AST_WAKE_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(changeFlag) |-> wakeReq); // R7
endmodule

// File: tb/pin_change_monitor_tb.sv
module pin_change_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] WATCH = 8'hF0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] pinLevel = 8'h00;
  logic [7:0] dirIsInput = 8'hFF;
  logic portAccess = 1'b0;
  logic flagClear = 1'b0;
  logic pullUpEnN = 1'b1;
  logic changeFlag, wakeReq;
  logic [7:0] pullUpOn;

  int nChecks = 0;
  int nFails = 0;
  logic [7:0] refM = 8'h00;
  logic flagM = 1'b0;
  logic [7:0] pullM = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_change_monitor dut_i (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .dirIsInput(dirIsInput),
    .portAccess(portAccess), .flagClear(flagClear), .pullUpEnN(pullUpEnN),
    .changeFlag(changeFlag), .wakeReq(wakeReq), .pullUpOn(pullUpOn)
  );

  function automatic logic modelMismatch(logic [7:0] pins, logic [7:0] dir, logic [7:0] rf);
    return |(WATCH & dir & (pins ^ rf));
  endfunction

  // advance one edge, updating the model from the inputs seen at that edge
  task automatic step();
    logic mm;
    @(posedge clk);
    if (!rstN) begin
      refM = pinLevel; flagM = 1'b0; pullM = 8'h00;
    end else begin
      mm = modelMismatch(pinLevel, dirIsInput, refM);
      if (mm) flagM = 1'b1;
      else if (flagClear) flagM = 1'b0;
      if (portAccess) refM = pinLevel;
      pullM = pullUpEnN ? 8'h00 : dirIsInput;
    end
    #1;
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkAll(string tag);
    chk({tag, " flag"}, {7'd0, changeFlag}, {7'd0, flagM});
    chk("R7 wake", {7'd0, wakeReq}, {7'd0, changeFlag});
    chk("R8 pull", pullUpOn, pullM);
  endtask

  initial begin
    fork
      begin
        // R9: reset state
        pinLevel = 8'hA5; dirIsInput = 8'hFF; pullUpEnN = 1'b0;
        repeat (3) step();
        chk("R9 reset flag", {7'd0, changeFlag}, 8'h00);
        chk("R9 reset pull", pullUpOn, 8'h00);
        rstN = 1'b1; pullUpEnN = 1'b1;
        repeat (3) step();
        chkAll("R9 no spurious");
        chk("R9 flag low", {7'd0, changeFlag}, 8'h00);
        // R1: low pins ignored
        pinLevel = 8'hAA; step(); pinLevel = 8'hA0; step();
        chkAll("R1");
        chk("R1 flag low", {7'd0, changeFlag}, 8'h00);
        // R2: watched pins as outputs ignored
        dirIsInput = 8'h0F; pinLevel = 8'h50; step(); step();
        chkAll("R2");
        chk("R2 flag low", {7'd0, changeFlag}, 8'h00);
        // R10: back to input with level equal to reference
        pinLevel = 8'hA0; step(); dirIsInput = 8'hFF; step(); step();
        chkAll("R10");
        chk("R10 flag low", {7'd0, changeFlag}, 8'h00);
        // R3: mismatch on pin 4
        pinLevel = 8'hB0; step();
        chkAll("R3");
        chk("R3 flag set", {7'd0, changeFlag}, 8'h01);
        chk("R7 wake set", {7'd0, wakeReq}, 8'h01);
        // R4: clear while mismatch persists
        flagClear = 1'b1; step(); flagClear = 1'b0;
        chkAll("R4");
        chk("R4 flag held", {7'd0, changeFlag}, 8'h01);
        // R6: access plus clear on same edge, old reference still mismatches
        portAccess = 1'b1; flagClear = 1'b1; step(); portAccess = 1'b0;
        chkAll("R6");
        chk("R6 set wins", {7'd0, changeFlag}, 8'h01);
        // R5: clear after recapture
        step();
        chkAll("R5");
        chk("R5 cleared", {7'd0, changeFlag}, 8'h00);
        flagClear = 1'b0;
        // R11: sticky after mismatch goes away
        pinLevel = 8'h30; step(); pinLevel = 8'hB0; step(); step();
        chkAll("R11");
        chk("R11 sticky", {7'd0, changeFlag}, 8'h01);
        flagClear = 1'b1; step(); flagClear = 1'b0;
        chk("R11 then clear", {7'd0, changeFlag}, 8'h00);
        // R8: pull-ups follow direction
        pullUpEnN = 1'b0; dirIsInput = 8'h3C; step();
        chkAll("R8");
        chk("R8 pattern", pullUpOn, 8'h3C);
        // random phase
        for (int i = 0; i < 3000; i++) begin
          if ($urandom_range(0, 7) == 0) pinLevel = pinLevel ^ (8'h01 << $urandom_range(0, 7));
          if ($urandom_range(0, 15) == 0) dirIsInput = 8'($urandom);
          if ($urandom_range(0, 31) == 0) pullUpEnN = ~pullUpEnN;
          portAccess = ($urandom_range(0, 5) == 0);
          flagClear = ($urandom_range(0, 3) == 0);
          step();
          chkAll("R3 random");
        end
        portAccess = 1'b0; flagClear = 1'b0;
      end
      begin
        repeat (100000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule